// File: doc/BRIEF.md
# Programmable Three-Input Logic Cell

This block is one cell of a small programmable-logic fabric. For each of its three lookup inputs it picks a source from a fixed menu. The menu holds a constant zero, the cell's own registered output, the output of a neighbouring cell, a conditioned event line, an I/O pin, a comparator signal, a serial-pad signal and four timer waveform signals. The three chosen bits form an index into an 8-bit truth value, so any Boolean function of three variables can be built.

The raw result can pass straight through, go through a two-flop synchronizer, or go through a glitch filter that needs three stable clocks. An optional rising-edge detector then turns it into one-clock pulses. The result drives a registered level output and a gated event output.

A single 32-bit control word sets the whole cell. It is written and read through a plain write strobe and a read-data bus. While the cell's enable bit is set, the word is locked and only the enable bit itself can change.

Top module: `lutcell`

## Requirements
- R1: The output follows truth bit TRUTH[{in2,in1,in0}]. TRUTH sits at control bits 31:24. The select fields are bits 19:16 for in2, 15:12 for in1 and 11:8 for in0. With no conditioning, lut_out shows the value one clock after the control write that enables the cell.
- R2: Select codes work as follows. 0x0 forces the input to 0 and 0x1 gives the cell's own lut_out. 0x2 gives link_in and 0x3 gives the conditioned event. 0x4 gives io_pin, 0x5 gives cmp_in and 0x6 gives pad_in. Codes 0x7 to 0xA give tmr_wo[0] to tmr_wo[3]. Codes 0xB to 0xF act as 0.
- R3: The conditioned event is event_in XOR bit 20, gated by bit 21. When bit 21 is 0 the event reads as 0.
- R4: Conditioning select bits 5:4 choose the path. Value 0 is a direct path. Value 1 adds a two-flop synchronizer, so lut_out changes three clocks after the enabling write. Value 3 behaves like 0.
- R5: Value 2 of bits 5:4 adds a filter after the synchronizer. A new level passes only after it has been seen for 3 consecutive clocks. A 2-clock glitch never reaches lut_out.
- R6: With bit 7 set, lut_out carries a one-clock high pulse on each rising edge of the conditioned level. It reads 0 while that level stays high.
- R7: event_out equals lut_out when bit 22 is set and is 0 otherwise.
- R8: While the enable bit (bit 1) is 1, a write changes no field other than bit 1.
- R9: A write with bit 1 cleared is accepted even while the word is locked, and it clears the enable.
- R10: While disabled, lut_out and event_out are 0 from the next clock on. The synchronizer, filter and edge state are cleared.
- R11: After reset the control word and both outputs are 0. Unimplemented bits (23, 6, 3, 2, 0) read 0, so the implemented-bit mask is 0xFF7FFFB2.
- R12: With feedback selected, the cell's own lut_out is used as an input on the next evaluation. An inverter built on feedback toggles every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word read-back |
| event_in | input | 1 | Incoming event line |
| link_in | input | 1 | Neighbouring cell output |
| io_pin | input | 1 | I/O pin input |
| cmp_in | input | 1 | Comparator input |
| pad_in | input | 1 | Serial-peripheral pad input |
| tmr_wo | input | 4 | Timer waveform inputs |
| lut_out | output | 1 | Registered cell output |
| event_out | output | 1 | Gated event output |

## Verification
Some properties are checked by assertions on every cycle. They cover the freeze of all non-enable fields while locked and the acceptance of an enable-clearing write. They also cover the quiet outputs after a disabled cycle, event_out never being high without lut_out, and edge-mode pulses lasting exactly one clock. The filter holding its level while the synchronized input agrees with it is checked the same way. Only the bench scenarios show the truth-table indexing for each source code, the synchronizer and filter latencies counted from the enabling write, glitch rejection, the feedback oscillation and the read-back mask.

// File: rtl/lutcell_pkg.sv
package lutcell_pkg;
  localparam int CFG_W   = 32;
  localparam int SEL_W   = 4;
  localparam int N_IN    = 3;
  localparam int N_TMR   = 4;

  // control word field positions
  localparam int POS_TRUTH  = 24;
  localparam int POS_EVO    = 22;
  localparam int POS_EVI    = 21;
  localparam int POS_EVINV  = 20;
  localparam int POS_SEL0   = 8;
  localparam int POS_EDGE   = 7;
  localparam int POS_FILT   = 4;
  localparam int POS_EN     = 1;
  localparam logic [CFG_W-1:0] CFG_MASK = 32'hFF7F_FFB2;

  // input source codes
  localparam logic [SEL_W-1:0] SRC_ZERO = 4'h0;
  localparam logic [SEL_W-1:0] SRC_FB   = 4'h1;
  localparam logic [SEL_W-1:0] SRC_LINK = 4'h2;
  localparam logic [SEL_W-1:0] SRC_EVT  = 4'h3;
  localparam logic [SEL_W-1:0] SRC_IO   = 4'h4;
  localparam logic [SEL_W-1:0] SRC_CMP  = 4'h5;
  localparam logic [SEL_W-1:0] SRC_PAD  = 4'h6;
  localparam int               SRC_TMR0 = 7;

  typedef enum logic [1:0] {
    COND_DIRECT = 2'd0,
    COND_SYNC   = 2'd1,
    COND_FILTER = 2'd2,
    COND_RSVD   = 2'd3
  } cond_mode_e;
endpackage

// File: rtl/lutcell_ctrl.sv
module lutcell_ctrl #(
  parameter int                 W      = 32,
  parameter logic [W-1:0]       MASK   = '1,
  parameter int                 EN_POS = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cfg_q
);
  localparam logic [W-1:0] EN_ONLY = W'(1) << EN_POS;

  logic locked;
  assign locked = cfg_q[EN_POS];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (wr) begin
      if (locked)
        cfg_q <= (cfg_q & ~EN_ONLY) | (wdata & EN_ONLY);
      else
        cfg_q <= wdata & MASK;
    end
  end

  // R8: nothing but the enable bit moves while locked
  a_r8_locked_fields: assert property (@(posedge clk) disable iff (rst)
    locked |=> ((cfg_q & ~EN_ONLY) == $past(cfg_q & ~EN_ONLY)));

  // R9: a clearing write is honoured even when locked
  a_r9_unlock_write: assert property (@(posedge clk) disable iff (rst)
    (locked && wr && !wdata[EN_POS]) |=> !cfg_q[EN_POS]);
endmodule

// File: rtl/lutcell_insel.sv
module lutcell_insel
  import lutcell_pkg::*;
#(
  parameter int NI  = 3,
  parameter int SW  = 4,
  parameter int NT  = 4
) (
  input  logic [NI*SW-1:0] sel,
  input  logic             fb,
  input  logic             link,
  input  logic             evt,
  input  logic             io,
  input  logic             cmp,
  input  logic             pad,
  input  logic [NT-1:0]    tmr,
  output logic [NI-1:0]    lut_in
);
  for (genvar g = 0; g < NI; g++) begin : g_mux
    logic [SW-1:0] code;
    assign code = sel[g*SW +: SW];

    always_comb begin
      lut_in[g] = 1'b0;
      case (code)
        SRC_ZERO: lut_in[g] = 1'b0;
        SRC_FB:   lut_in[g] = fb;
        SRC_LINK: lut_in[g] = link;
        SRC_EVT:  lut_in[g] = evt;
        SRC_IO:   lut_in[g] = io;
        SRC_CMP:  lut_in[g] = cmp;
        SRC_PAD:  lut_in[g] = pad;
        default: begin
          for (int t = 0; t < NT; t++)
            if (int'(code) == SRC_TMR0 + t) lut_in[g] = tmr[t];
        end
      endcase
    end
  end
endmodule

// File: rtl/lutcell_cond.sv
module lutcell_cond
  import lutcell_pkg::*;
#(
  parameter int SYNC_DEPTH = 2,
  parameter int FILT_LEN   = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic [1:0] mode,
  input  logic       edge_en,
  input  logic       raw,
  output logic       nxt
);
  localparam int CNT_W = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

  logic [SYNC_DEPTH-1:0] sync_q;
  logic                  s_last;
  logic                  filt_q;
  logic [CNT_W-1:0]      cnt_q;
  logic                  level;
  logic                  prev_q;

  always_ff @(posedge clk) begin
    if (rst || !en) sync_q <= '0;
    else            sync_q <= {sync_q[SYNC_DEPTH-2:0], raw};
  end
  assign s_last = sync_q[SYNC_DEPTH-1];

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else if (s_last != filt_q) begin
      if (cnt_q == CNT_W'(FILT_LEN - 1)) begin
        filt_q <= s_last;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end

  always_comb begin
    case (cond_mode_e'(mode))
      COND_SYNC:   level = s_last;
      COND_FILTER: level = filt_q;
      default:     level = raw;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !en) prev_q <= 1'b0;
    else            prev_q <= level;
  end

  assign nxt = edge_en ? (level & ~prev_q) : level;

  // R5: the filter holds while the synchronized value agrees
  a_r5_filter_hold: assert property (@(posedge clk) disable iff (rst)
    (en && mode == COND_FILTER && s_last == filt_q) |=> (filt_q == $past(filt_q)));
endmodule

// File: rtl/lutcell.sv
module lutcell
  import lutcell_pkg::*;
#(
  parameter int SYNC_DEPTH = 2,
  parameter int FILT_LEN   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic [CFG_W-1:0] reg_wdata,
  output logic [CFG_W-1:0] reg_rdata,
  input  logic             event_in,
  input  logic             link_in,
  input  logic             io_pin,
  input  logic             cmp_in,
  input  logic             pad_in,
  input  logic [N_TMR-1:0] tmr_wo,
  output logic             lut_out,
  output logic             event_out
);
  localparam int TRUTH_N = 1 << N_IN;

  logic [CFG_W-1:0]       cfg;
  logic [TRUTH_N-1:0]     truth;
  logic [N_IN*SEL_W-1:0]  sels;
  logic                   en, evo_en, edge_en;
  logic [1:0]             mode;
  logic                   evt;
  logic [N_IN-1:0]        lut_in;
  logic                   raw, nxt;

  lutcell_ctrl #(.W(CFG_W), .MASK(CFG_MASK), .EN_POS(POS_EN)) i_ctrl (
    .clk(clk), .rst(rst), .wr(reg_wr), .wdata(reg_wdata), .cfg_q(cfg)
  );

  assign reg_rdata = cfg;
  assign truth     = cfg[POS_TRUTH +: TRUTH_N];
  assign sels      = cfg[POS_SEL0 +: N_IN*SEL_W];
  assign en        = cfg[POS_EN];
  assign evo_en    = cfg[POS_EVO];
  assign edge_en   = cfg[POS_EDGE];
  assign mode      = cfg[POS_FILT +: 2];
  assign evt       = cfg[POS_EVI] & (event_in ^ cfg[POS_EVINV]);

  lutcell_insel #(.NI(N_IN), .SW(SEL_W), .NT(N_TMR)) i_insel (
    .sel(sels), .fb(lut_out), .link(link_in), .evt(evt), .io(io_pin),
    .cmp(cmp_in), .pad(pad_in), .tmr(tmr_wo), .lut_in(lut_in)
  );

  assign raw = truth[lut_in];

  lutcell_cond #(.SYNC_DEPTH(SYNC_DEPTH), .FILT_LEN(FILT_LEN)) i_cond (
    .clk(clk), .rst(rst), .en(en), .mode(mode), .edge_en(edge_en),
    .raw(raw), .nxt(nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lut_out   <= 1'b0;
      event_out <= 1'b0;
    end else begin
      lut_out   <= en & nxt;
      event_out <= en & evo_en & nxt;
    end
  end

  // R10: quiet outputs after a disabled cycle
  a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!lut_out && !event_out));

  // R7: the event output never runs without the level output
  a_r7_evout_subset: assert property (@(posedge clk) disable iff (rst)
    event_out |-> lut_out);

  // R6: edge mode pulses last one clock
  a_r6_edge_single: assert property (@(posedge clk) disable iff (rst)
    (edge_en && en && lut_out) |=> !lut_out);
endmodule

// File: tb/test_lutcell.sv
`timescale 1ns/1ps
module test_lutcell;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        event_in = 0, link_in = 0, io_pin = 0, cmp_in = 0, pad_in = 0;
  logic [3:0]  tmr_wo = '0;
  logic        lut_out, event_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  lutcell i_lutcell (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .event_in(event_in), .link_in(link_in),
    .io_pin(io_pin), .cmp_in(cmp_in), .pad_in(pad_in), .tmr_wo(tmr_wo),
    .lut_out(lut_out), .event_out(event_out)
  );

  // {cfg[31:0], stim {event,link,io,cmp,pad,tmr[3:0]}, expected}
  localparam int NV = 16;
  localparam logic [41:0] VEC [NV] = '{
    {32'h8006_5402, 9'b0_0_111_0000, 1'b1},  // R1 AND io/cmp/pad
    {32'h8006_5402, 9'b0_0_011_0000, 1'b0},  // R1 one input low
    {32'h9609_8702, 9'b0_0_000_0011, 1'b0},  // R2 xor tmr0..2
    {32'h9609_8702, 9'b0_0_000_0111, 1'b1},  // R2 xor tmr0..2
    {32'h0200_0A02, 9'b0_0_000_1000, 1'b1},  // R2 tmr3
    {32'h0100_0B02, 9'b1_1_111_1111, 1'b1},  // R2 reserved masks
    {32'h0100_0F02, 9'b1_1_111_1111, 1'b1},  // R2 reserved masks
    {32'h0220_0302, 9'b1_0_000_0000, 1'b1},  // R3 event on
    {32'h0220_0302, 9'b0_0_000_0000, 1'b0},  // R3 event low
    {32'h0230_0302, 9'b0_0_000_0000, 1'b1},  // R3 inverted
    {32'h0200_0302, 9'b1_0_000_0000, 1'b0},  // R3 gated off
    {32'h0400_2002, 9'b0_1_000_0000, 1'b1},  // R2 link on in1
    {32'h8006_5412, 9'b0_0_111_0000, 1'b1},  // R4 sync steady
    {32'h8006_5432, 9'b0_0_111_0000, 1'b1},  // R4 mode 3 direct
    {32'h8006_5422, 9'b0_0_111_0000, 1'b1},  // R5 filter steady
    {32'h8006_5482, 9'b0_0_111_0000, 1'b0}   // R6 edge steady high
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic stim(input logic [8:0] s);
    {event_in, link_in, io_pin, cmp_in, pad_in, tmr_wo} = s;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    finish_run();
  end

  initial begin
    logic seen0;
    tick(3);
    rst = 1'b0;
    tick(1);
    check("R11 reset word", reg_rdata, 32'h0);
    check("R11 reset out", {31'b0, lut_out}, 32'h0);
    check("R11 reset evout", {31'b0, event_out}, 32'h0);

    for (int v = 0; v < NV; v++) begin
      wr(32'h0);
      stim(VEC[v][9:1]);
      wr(VEC[v][41:10]);
      tick(8);
      check($sformatf("R1 vector %0d", v), {31'b0, lut_out}, {31'b0, VEC[v][0]});
    end

    // R11 read-back mask
    wr(32'h0);
    wr(32'hFFFF_FFFD);
    check("R11 mask", reg_rdata, 32'hFF7F_FFB0);
    wr(32'h0);

    // R1 direct latency
    stim(9'b0_0_111_0000);
    wr(32'h8006_5402);
    check("R1 latency before", {31'b0, lut_out}, 0);
    tick(1);
    check("R1 latency after", {31'b0, lut_out}, 1);
    check("R7 evout off", {31'b0, event_out}, 0);

    // R8 locked write ignored
    wr(32'h0000_0002);
    check("R8 word held", reg_rdata, 32'h8006_5402);
    tick(2);
    check("R8 out held", {31'b0, lut_out}, 1);
    // R9 clear accepted, R10 quiet
    wr(32'h8006_5400);
    check("R9 enable cleared", reg_rdata, 32'h8006_5400);
    tick(1);
    check("R10 out cleared", {31'b0, lut_out}, 0);
    wr(32'h0000_0000);
    check("R9 reconfigurable", reg_rdata, 32'h0);

    // R7 event out
    wr(32'h8046_5402);
    tick(2);
    check("R7 evout on", {31'b0, event_out}, 1);
    wr(32'h8046_5400);
    tick(1);
    check("R10 evout cleared", {31'b0, event_out}, 0);
    wr(32'h0);

    // R4 synchronizer latency
    wr(32'h8006_5412);
    tick(2);
    check("R4 sync early", {31'b0, lut_out}, 0);
    tick(1);
    check("R4 sync on time", {31'b0, lut_out}, 1);
    wr(32'h0);

    // R5 filter latency and glitch rejection
    wr(32'h8006_5422);
    tick(5);
    check("R5 filter early", {31'b0, lut_out}, 0);
    tick(1);
    check("R5 filter on time", {31'b0, lut_out}, 1);
    io_pin = 1'b0;
    tick(2);
    io_pin = 1'b1;
    for (int k = 0; k < 8; k++) begin
      tick(1);
      check("R5 glitch rejected", {31'b0, lut_out}, 1);
    end
    io_pin = 1'b0;
    tick(3);
    io_pin = 1'b1;
    seen0 = 1'b0;
    for (int k = 0; k < 8; k++) begin
      tick(1);
      if (!lut_out) seen0 = 1'b1;
    end
    check("R5 three-clock low passes", {31'b0, seen0}, 1);
    wr(32'h0);

    // R6 rising-edge pulse
    io_pin = 1'b0;
    wr(32'h8006_5482);
    tick(2);
    check("R6 idle", {31'b0, lut_out}, 0);
    io_pin = 1'b1;
    tick(1);
    check("R6 pulse", {31'b0, lut_out}, 1);
    tick(1);
    check("R6 pulse ends", {31'b0, lut_out}, 0);
    wr(32'h0);

    // R12 feedback inverter
    wr(32'h0100_0102);
    check("R12 start", {31'b0, lut_out}, 0);
    tick(1);
    check("R12 toggle 1", {31'b0, lut_out}, 1);
    tick(1);
    check("R12 toggle 0", {31'b0, lut_out}, 0);
    tick(1);
    check("R12 toggle 1 again", {31'b0, lut_out}, 1);
    wr(32'h0);

    finish_run();
  end
endmodule